// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This execution unit performs signed fixed-point DSP arithmetic on operands that have already been read from a register file. Each operation is selected by a 4-bit code. The unit covers three groups of work. The first is saturating add and subtract, with or without a doubled second operand. The second is halfword multiplies, which can accumulate into 32 bits or into a 64-bit register pair. The third is a 32x16 multiply that keeps the upper 32 bits of its 48-bit product.

When `in_valid` is high, the result is captured at the next rising clock edge and appears one cycle later with `out_valid`. A sticky flag records every saturation event and every accumulate overflow. It stays set until `sat_clr` is asserted, so a block of code can check once, at its end, whether any step clipped.

Top module: `dsp_sat_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from the previous rising edge. While `in_valid` is low, `res_lo` and `res_hi` keep their last values.
- R2: A synchronous active-high `rst` clears `out_valid`, `res_lo`, `res_hi` and `sat_flag` to zero.
- R3: Saturating add (code 0) and subtract (code 1) give `a+b` or `a-b`. Signed overflow clamps the result to 0x7FFFFFFF when positive and to 0x80000000 when negative, and sets the flag.
- R4: The doubling add (code 2) and doubling subtract (code 3) first form `2*b` with saturation, then add it to or subtract it from `a` with saturation. Either step sets the flag when it clips.
- R5: In every halfword multiply, `sel_a` picks bits 31:16 of `a` when 1 and bits 15:0 when 0, and `sel_b` does the same for `b`. The chosen half is sign-extended from its bit 15.
- R6: The 16x16 multiply (code 4) returns the 32-bit signed product and leaves the flag unchanged.
- R7: The 16x16 multiply-accumulate (code 5) returns `product + c` modulo 2^32. It sets the flag when that signed addition overflows.
- R8: The 32x16 multiply (code 6) returns bits 47:16 of signed `a` times the halfword of `b` chosen by `sel_b`. The accumulate form (code 7) adds `c` modulo 2^32 and sets the flag on signed overflow.
- R9: The long accumulate (code 8) adds the sign-extended 16x16 product to the 64-bit value `{d, c}`. It returns the high half on `res_hi` and the low half on `res_lo`, and leaves the flag unchanged.
- R10: The flag stays set until `sat_clr` is high at a clock edge that carries no new saturation event. A clear and an event in the same cycle leave the flag set.
- R11: For every code other than 8, `res_hi` is zero. Unused codes 9 to 15 return zero and raise no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| sel_a | input | 1 | Upper-half select for operand a |
| sel_b | input | 1 | Upper-half select for operand b |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| opnd_c | input | 32 | Accumulate value / low half of pair |
| opnd_d | input | 32 | High half of accumulate pair |
| sat_clr | input | 1 | Clears the sticky flag |
| out_valid | output | 1 | Result registered last cycle |
| res_lo | output | 32 | Result, or low half of long result |
| res_hi | output | 32 | High half of long result, else zero |
| sat_flag | output | 1 | Sticky saturation/overflow flag |

## Verification
The hardest case to reach is the doubling path. Its first step can clip while the second step still lands in range, and the only sign of that is the flag and the clamped value of `2*b`. The stimulus targets this by choosing `b` just past the quarter range with `a` at zero and at small values. It also drives a clear in the same cycle as a clipping subtract, and a clear alongside a flag-neutral multiply, so that the priority between the two can be seen.

// File: rtl/dsp_sat_pkg.sv
package dsp_sat_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_QADD  = 4'd0,
        OP_QSUB  = 4'd1,
        OP_QDADD = 4'd2,
        OP_QDSUB = 4'd3,
        OP_MUL16 = 4'd4,
        OP_MAC16 = 4'd5,
        OP_MULW  = 4'd6,
        OP_MACW  = 4'd7,
        OP_MACL  = 4'd8
    } dsp_op_e;
endpackage

// File: rtl/dsp_sat_addsub.sv
module dsp_sat_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    input  logic          dbl,
    output logic [DW-1:0] res,
    output logic          ovf
);
    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0]   dsum;
    logic [DW:0]   tot;
    logic [DW-1:0] dop;
    logic          d_ovf;
    logic          t_ovf;

    always_comb begin
        dsum  = {b[DW-1], b} + {b[DW-1], b};
        d_ovf = dbl && (dsum[DW] != dsum[DW-1]);
        if (!dbl)
            dop = b;
        else if (d_ovf)
            dop = b[DW-1] ? MINV : MAXV;
        else
            dop = dsum[DW-1:0];

        if (sub)
            tot = {a[DW-1], a} - {dop[DW-1], dop};
        else
            tot = {a[DW-1], a} + {dop[DW-1], dop};
        t_ovf = (tot[DW] != tot[DW-1]);
        res   = t_ovf ? (tot[DW] ? MINV : MAXV) : tot[DW-1:0];
        ovf   = d_ovf | t_ovf;
    end
endmodule

// File: rtl/dsp_sat_mul.sv
module dsp_sat_mul #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sel_a,
    input  logic          sel_b,
    output logic [DW-1:0] p_hh,
    output logic [DW-1:0] p_wh
);
    localparam int HW = DW / 2;
    localparam int PW = DW + HW;

    logic signed [HW-1:0] ha;
    logic signed [HW-1:0] hb;
    logic signed [DW-1:0] php;
    logic signed [PW-1:0] pw;

    always_comb begin
        ha   = sel_a ? a[DW-1:HW] : a[HW-1:0];
        hb   = sel_b ? b[DW-1:HW] : b[HW-1:0];
        php  = ha * hb;
        pw   = $signed(a) * hb;
        p_hh = php;
        p_wh = DW'(pw >>> HW);
    end
endmodule

// File: rtl/dsp_sat_acc.sv
module dsp_sat_acc #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] p_hh,
    input  logic [DW-1:0] p_wh,
    input  logic [DW-1:0] c,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] mac16_res,
    output logic          mac16_ovf,
    output logic [DW-1:0] macw_res,
    output logic          macw_ovf,
    output logic [DW-1:0] long_lo,
    output logic [DW-1:0] long_hi
);
    localparam int LW = 2 * DW;

    logic [DW:0]   s16;
    logic [DW:0]   sw;
    logic [LW-1:0] sl;

    always_comb begin
        s16       = {p_hh[DW-1], p_hh} + {c[DW-1], c};
        sw        = {p_wh[DW-1], p_wh} + {c[DW-1], c};
        sl        = {d, c} + {{DW{p_hh[DW-1]}}, p_hh};
        mac16_res = s16[DW-1:0];
        mac16_ovf = s16[DW] ^ s16[DW-1];
        macw_res  = sw[DW-1:0];
        macw_ovf  = sw[DW] ^ sw[DW-1];
        long_lo   = sl[DW-1:0];
        long_hi   = sl[LW-1:DW];
    end
endmodule

// File: rtl/dsp_sat_unit.sv
module dsp_sat_unit
    import dsp_sat_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [3:0]    op,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    input  logic [DW-1:0] opnd_c,
    input  logic [DW-1:0] opnd_d,
    input  logic          sat_clr,
    output logic          out_valid,
    output logic [DW-1:0] res_lo,
    output logic [DW-1:0] res_hi,
    output logic          sat_flag
);
    dsp_op_e       op_e;
    logic          as_sub;
    logic          as_dbl;
    logic [DW-1:0] as_res;
    logic          as_ovf;
    logic [DW-1:0] p_hh;
    logic [DW-1:0] p_wh;
    logic [DW-1:0] mac16_res;
    logic          mac16_ovf;
    logic [DW-1:0] macw_res;
    logic          macw_ovf;
    logic [DW-1:0] long_lo;
    logic [DW-1:0] long_hi;
    logic [DW-1:0] nxt_lo;
    logic [DW-1:0] nxt_hi;
    logic          nxt_ev;

    always_comb begin
        op_e   = dsp_op_e'(op);
        as_sub = (op_e == OP_QSUB) || (op_e == OP_QDSUB);
        as_dbl = (op_e == OP_QDADD) || (op_e == OP_QDSUB);
    end

    dsp_sat_addsub #(.DW(DW)) u_addsub (
        .a   (opnd_a),
        .b   (opnd_b),
        .sub (as_sub),
        .dbl (as_dbl),
        .res (as_res),
        .ovf (as_ovf)
    );

    dsp_sat_mul #(.DW(DW)) u_mul (
        .a     (opnd_a),
        .b     (opnd_b),
        .sel_a (sel_a),
        .sel_b (sel_b),
        .p_hh  (p_hh),
        .p_wh  (p_wh)
    );

    dsp_sat_acc #(.DW(DW)) u_acc (
        .p_hh      (p_hh),
        .p_wh      (p_wh),
        .c         (opnd_c),
        .d         (opnd_d),
        .mac16_res (mac16_res),
        .mac16_ovf (mac16_ovf),
        .macw_res  (macw_res),
        .macw_ovf  (macw_ovf),
        .long_lo   (long_lo),
        .long_hi   (long_hi)
    );

    // Result select
    always_comb begin
        nxt_lo = '0;
        nxt_hi = '0;
        nxt_ev = 1'b0;
        case (op_e)
            OP_QADD, OP_QSUB, OP_QDADD, OP_QDSUB: begin
                nxt_lo = as_res;
                nxt_ev = as_ovf;
            end
            OP_MUL16: nxt_lo = p_hh;
            OP_MAC16: begin
                nxt_lo = mac16_res;
                nxt_ev = mac16_ovf;
            end
            OP_MULW:  nxt_lo = p_wh;
            OP_MACW: begin
                nxt_lo = macw_res;
                nxt_ev = macw_ovf;
            end
            OP_MACL: begin
                nxt_lo = long_lo;
                nxt_hi = long_hi;
            end
            default: begin
                nxt_lo = '0;
                nxt_hi = '0;
                nxt_ev = 1'b0;
            end
        endcase
    end

    // Result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_lo <= nxt_lo;
                res_hi <= nxt_hi;
            end
        end
    end

    // Sticky flag: a new event wins over a clear
    always_ff @(posedge clk) begin
        if (rst)
            sat_flag <= 1'b0;
        else
            sat_flag <= (sat_flag & ~sat_clr) | (in_valid & nxt_ev);
    end
endmodule

// File: rtl/dsp_sat_chk.sv
module dsp_sat_chk
    import dsp_sat_pkg::*;
#(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [3:0]    op,
    input logic [DW-1:0] opnd_a,
    input logic [DW-1:0] opnd_b,
    input logic          sat_clr,
    input logic          out_valid,
    input logic [DW-1:0] res_lo,
    input logic [DW-1:0] res_hi,
    input logic          sat_flag
);
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(res_lo) && $stable(res_hi)));

    assert_add_pos_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_QADD && !opnd_a[DW-1] && !opnd_b[DW-1]) |=> !res_lo[DW-1]);

    assert_add_neg_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_QADD && opnd_a[DW-1] && opnd_b[DW-1]) |=> res_lo[DW-1]);

    assert_mul_flag_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MUL16 && !sat_clr) |=> (sat_flag == $past(sat_flag)));

    assert_long_flag_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MACL && !sat_clr) |=> (sat_flag == $past(sat_flag)));

    assert_clear_alone_R10: assert property (@(posedge clk) disable iff (rst)
        (sat_clr && !in_valid) |=> !sat_flag);

    assert_flag_rise_needs_op_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_flag) |-> $past(in_valid));

    assert_hi_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op != OP_MACL) |=> (res_hi == '0));
endmodule

bind dsp_sat_unit dsp_sat_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op        (op),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .sat_clr   (sat_clr),
    .out_valid (out_valid),
    .res_lo    (res_lo),
    .res_hi    (res_hi),
    .sat_flag  (sat_flag)
);

// File: tb/sim_dsp_sat_unit.sv
`timescale 1ns/1ps
module sim_dsp_sat_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [3:0]  op;
    logic        sel_a;
    logic        sel_b;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] opnd_c;
    logic [31:0] opnd_d;
    logic        sat_clr;
    logic        out_valid;
    logic [31:0] res_lo;
    logic [31:0] res_hi;
    logic        sat_flag;

    typedef struct {
        logic [31:0] lo;
        logic [31:0] hi;
        logic        fl;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          model_flag = 1'b0;
    logic [31:0] last_lo = '0;
    logic [31:0] last_hi = '0;

    always #2 clk = ~clk;

    dsp_sat_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .opnd_c(opnd_c), .opnd_d(opnd_d), .sat_clr(sat_clr),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi), .sat_flag(sat_flag)
    );

    function automatic logic [31:0] sat_l(longint v, inout bit o);
        if (v > 64'sd2147483647) begin o = 1'b1; return 32'h7FFF_FFFF; end
        if (v < -64'sd2147483648) begin o = 1'b1; return 32'h8000_0000; end
        return 32'(v);
    endfunction

    function automatic bit out_of_range(longint v);
        return (v > 64'sd2147483647) || (v < -64'sd2147483648);
    endfunction

    function automatic longint half(logic [31:0] x, logic s);
        logic signed [15:0] h;
        h = s ? x[31:16] : x[15:0];
        return longint'(h);
    endfunction

    function automatic longint sx(logic [31:0] x);
        return longint'($signed(x));
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic issue(logic [3:0] o, logic sa, logic sb, logic [31:0] a, logic [31:0] b,
                         logic [31:0] c, logic [31:0] d, logic clr, string tag);
        exp_t   e;
        bit     ev;
        longint v;
        longint w;
        logic [31:0] dd;
        @(negedge clk);
        in_valid = 1'b1; op = o; sel_a = sa; sel_b = sb;
        opnd_a = a; opnd_b = b; opnd_c = c; opnd_d = d; sat_clr = clr;
        ev = 1'b0;
        e.hi = '0;
        case (o)
            4'd0: e.lo = sat_l(sx(a) + sx(b), ev);
            4'd1: e.lo = sat_l(sx(a) - sx(b), ev);
            4'd2: begin dd = sat_l(2 * sx(b), ev); e.lo = sat_l(sx(a) + sx(dd), ev); end
            4'd3: begin dd = sat_l(2 * sx(b), ev); e.lo = sat_l(sx(a) - sx(dd), ev); end
            4'd4: e.lo = 32'(half(a, sa) * half(b, sb));
            4'd5: begin v = half(a, sa) * half(b, sb) + sx(c); ev = out_of_range(v); e.lo = 32'(v); end
            4'd6: e.lo = 32'((sx(a) * half(b, sb)) >>> 16);
            4'd7: begin
                w = sx(32'((sx(a) * half(b, sb)) >>> 16));
                v = w + sx(c); ev = out_of_range(v); e.lo = 32'(v);
            end
            4'd8: begin
                v = longint'({d, c}) + half(a, sa) * half(b, sb);
                e.lo = v[31:0]; e.hi = v[63:32];
            end
            default: e.lo = '0;
        endcase
        model_flag = (model_flag & !clr) | ev;
        e.fl = model_flag;
        e.tag = tag;
        last_lo = e.lo;
        last_hi = e.hi;
        q.push_back(e);
    endtask

    task automatic idle(logic clr);
        @(negedge clk);
        in_valid = 1'b0; sat_clr = clr;
        if (clr) model_flag = 1'b0;
    endtask

    // Monitor: pops the scoreboard as results emerge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk); #1;
            if (!rst && out_valid) begin
                if (q.size() == 0) begin
                    check("R1", "unexpected out_valid", 64'd1, 64'd0);
                end else begin
                    e = q.pop_front();
                    n_chk++;
                    if (res_lo !== e.lo || res_hi !== e.hi || sat_flag !== e.fl) begin
                        n_fail++;
                        $display("FAIL %s: actual lo=%h hi=%h flag=%b expected lo=%h hi=%h flag=%b",
                                 e.tag, res_lo, res_hi, sat_flag, e.lo, e.hi, e.fl);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R1 watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op = '0; sel_a = 1'b0; sel_b = 1'b0;
        opnd_a = '0; opnd_b = '0; opnd_c = '0; opnd_d = '0; sat_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R2", "reset state", {out_valid, sat_flag, res_lo, res_hi[29:0]},
              64'd0);
        if (res_hi !== 32'd0) check("R2", "reset res_hi", {32'd0, res_hi}, 64'd0);

        // R3 saturating add/sub
        issue(4'd0, 0, 0, 32'd1, 32'd2, 0, 0, 0, "R3 add in range");
        issue(4'd0, 0, 0, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, "R3 add positive clamp");
        idle(1);
        @(negedge clk); #1;
        check("R10", "clear alone drops flag", {63'd0, sat_flag}, 64'd0);
        issue(4'd1, 0, 0, 32'h8000_0000, 32'd1, 0, 0, 0, "R3 sub negative clamp");
        // R10 clear with no event clears; clear with event keeps set
        issue(4'd4, 0, 0, 32'd3, 32'd4, 0, 0, 1, "R10 clear with neutral op");
        issue(4'd1, 0, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, "R10 clear and clamp together");
        issue(4'd0, 0, 0, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, "R3 add negative clamp");
        // R4 doubling
        issue(4'd2, 0, 0, 32'd0, 32'h4000_0000, 0, 0, 1, "R4 doubling clips first step");
        issue(4'd2, 0, 0, 32'h8000_0000, 32'h4000_0000, 0, 0, 1, "R4 doubled clip then in range");
        issue(4'd3, 0, 0, 32'd10, 32'd3, 0, 0, 1, "R4 doubling sub in range");
        issue(4'd3, 0, 0, 32'hC000_0000, 32'h2000_0001, 0, 0, 0, "R4 doubling sub second step clips");
        // R5/R6 halfword selection and plain multiply
        issue(4'd4, 0, 0, 32'hFFFE_0003, 32'h0005_8000, 0, 0, 0, "R5 R6 low x low");
        issue(4'd4, 1, 1, 32'hFFFE_0003, 32'h0005_8000, 0, 0, 0, "R5 R6 high x high");
        issue(4'd4, 1, 0, 32'hFFFE_0003, 32'h0005_8000, 0, 0, 0, "R5 R6 high x low");
        issue(4'd4, 0, 1, 32'hFFFE_0003, 32'h0005_8000, 0, 0, 0, "R5 R6 low x high");
        issue(4'd4, 0, 0, 32'h0000_8000, 32'h0000_8000, 0, 0, 1, "R6 min x min, flag cleared");
        // R7 MAC16
        issue(4'd5, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 0, 0, "R7 mac wraps and flags");
        issue(4'd5, 1, 0, 32'h0007_0000, 32'h0000_FFFF, 32'd100, 0, 1, "R7 mac in range");
        // R8 32x16
        issue(4'd6, 0, 1, 32'h1234_5678, 32'h8000_0000, 0, 0, 0, "R8 wide multiply upper half");
        issue(4'd6, 0, 0, 32'hFFFF_FFFF, 32'h0000_0003, 0, 0, 0, "R8 wide multiply negative truncation");
        issue(4'd7, 0, 0, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 0, "R8 wide mac overflow");
        issue(4'd7, 0, 1, 32'h0001_0000, 32'h0002_0000, 32'd5, 0, 1, "R8 wide mac in range");
        // R9 long accumulate
        issue(4'd8, 0, 0, 32'd1, 32'd1, 32'hFFFF_FFFF, 32'd0, 0, "R9 long carry into high");
        issue(4'd5, 0, 0, 32'h0000_8000, 32'h0000_8000, 32'h7FFF_FFFF, 0, 0, "R7 set flag before long");
        issue(4'd8, 1, 0, 32'hFFFF_0000, 32'd2, 32'd0, 32'd0, 0, "R9 long borrow, flag kept");
        // R11 unused code
        issue(4'd12, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'd9, 32'd9, 0, "R11 unused code");
        issue(4'd8, 0, 0, 32'd2, 32'd3, 32'h1, 32'h5, 0, "R9 long plain");
        issue(4'd0, 0, 0, 32'd7, 32'd8, 0, 0, 0, "R11 hi cleared after long");
        // R1 hold while idle
        idle(0);
        @(negedge clk); #1;
        check("R1", "idle out_valid", {63'd0, out_valid}, 64'd0);
        check("R1", "idle hold", {res_hi, res_lo}, {last_hi, last_lo});
        repeat (3) @(negedge clk);
        check("R1", "scoreboard drained", 64'(q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule